// File: doc/BRIEF.md
# LIN Physical-Layer Mode Controller

This block is the digital control core of a single-wire LIN bus interface. It keeps the interface in one of three operating modes: sleep, stand-by and normal. From that mode it drives the enables for the inhibit output, the bus termination, the transmitter and the receiver. It also drives the level placed on the receive-data output and the strength of the pull-down on the transmit-data pin. In stand-by, those last two outputs tell the host controller why the interface woke. A stand-by entered by a wake-up pulls receive-data low. A stand-by entered at power-up leaves it high. Only a local wake-up selects the strong transmit-data pull-down.

The inputs are the enable pin, a power-on-reset pulse and two wake strobes. The wake strobes arrive already qualified by a separate glitch-filter block: one for bus (remote) wake-up and one for local wake-up. The enable pin passes through a synchronizer. Each mode change driven by enable waits a programmable settling delay, set from the clock frequency and a delay in microseconds (10 us by default). Wake-ups and power-on resets take effect on the next clock edge.

Top module: `lin_mode_ctrl`

## Requirements
- R1: After reset the block is in stand-by with power-up as the wake source. The outputs are then: inhibit on, termination on, transmitter off, receiver off, receive-data high, weak pull-down (strength select 0).
- R2: A high on the enable pin moves the block from stand-by or sleep to normal. The change comes exactly 2 + DLY clock edges after the pin is sampled high, where DLY = (CLK_HZ/1e6) * DELAY_US.
- R3: In normal mode inhibit, termination, transmitter and receiver are all on. Receive-data equals the bus receive input combinationally, and the pull-down is weak.
- R4: In normal mode, an enable held low for DLY synchronized cycles moves the block to sleep. If enable returns high before the delay expires, the countdown is cancelled and the block stays in normal.
- R5: In sleep, inhibit, termination, transmitter and receiver are off, receive-data is high and the pull-down is weak.
- R6: In sleep, with the synchronized enable low, a bus wake strobe moves the block to stand-by on the next edge. Receive-data then goes low and the pull-down stays weak.
- R7: In sleep, a local wake strobe moves the block to stand-by on the next edge, with receive-data low and the strong pull-down selected (select 1). When both wake strobes arrive together, the local wake-up wins.
- R8: In sleep, wake strobes are ignored while the synchronized enable is high. The block stays in sleep and then moves straight to normal when the enable delay expires.
- R9: A power-on-reset pulse in any mode moves the block to stand-by on the next edge, with power-up as the wake source (receive-data high, weak pull-down). Any pending enable countdown restarts from zero.
- R10: Wake strobes have no effect in stand-by or normal mode.
- R11: The latched wake source is cleared on entry to normal mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset (power-up) |
| en_pin | input | 1 | Asynchronous enable pin level |
| por_pulse | input | 1 | Supply power-on-reset pulse, one or more cycles |
| wake_bus | input | 1 | Qualified bus wake-up strobe |
| wake_local | input | 1 | Qualified local wake-up strobe |
| bus_rx | input | 1 | Received bus level from the comparator |
| inh_en | output | 1 | Inhibit output enable |
| term_en | output | 1 | Bus termination enable |
| tx_en | output | 1 | Transmitter enable |
| rx_en | output | 1 | Receiver enable |
| rxd_out | output | 1 | Level for the receive-data output |
| txd_pd_strong | output | 1 | Transmit-data pull-down strength: 1 strong, 0 weak |

## Verification
The hardest case to reach is a wake strobe that lands in sleep while the enable pin has already passed the synchronizer but its countdown has not expired. The block must then ignore the wake and go straight to normal. The bench reaches this case directly: it raises enable in sleep, waits for the two synchronizer stages and then fires a local wake strobe. A random phase also raises and drops enable at random instants, mixed with wake and power-on-reset pulses. A cycle-level reference model in the bench catches the remaining overlaps, such as a power-on reset that restarts a pending countdown.

// File: rtl/lin_mode_pkg.sv
// Shared types for the LIN mode controller.
package lin_mode_pkg;

    typedef enum logic [1:0] {
        MODE_SLEEP = 2'd0,
        MODE_STBY  = 2'd1,
        MODE_NORM  = 2'd2
    } lin_mode_e;

    typedef enum logic [1:0] {
        SRC_NONE  = 2'd0,
        SRC_POWER = 2'd1,
        SRC_BUS   = 2'd2,
        SRC_LOCAL = 2'd3
    } wake_src_e;

    typedef struct packed {
        logic inh;
        logic term;
        logic tx;
        logic rx;
    } stage_en_t;

endpackage

// File: rtl/lin_en_sync.sv
// Enable pin synchronizer.
// Takes the asynchronous enable pin through STAGES flops. Assumes STAGES >= 2.
// Reset clears every stage, so the enable reads low after reset.
module lin_en_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_pin,
    output logic en_lvl
);
    logic [STAGES-1:0] sync_q;

    // Shift the pin level through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[STAGES-2:0], en_pin};
    end

    assign en_lvl = sync_q[STAGES-1];
endmodule

// File: rtl/lin_mode_fsm.sv
// Mode state machine: sleep, stand-by and normal.
// Changes driven by enable wait DLY_CYC cycles of steady synchronized enable.
// Wake-ups and power-on reset act on the next edge.
// Assumes the wake strobes are already filtered and DLY_CYC >= 1.
module lin_mode_fsm
    import lin_mode_pkg::*;
#(
    parameter int DLY_CYC = 2000
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      en_lvl,
    input  logic      por,
    input  logic      wake_bus,
    input  logic      wake_local,
    output lin_mode_e mode,
    output logic      acc_bus,
    output logic      acc_loc,
    output logic      enter_norm
);
    localparam int CW = (DLY_CYC < 2) ? 1 : $clog2(DLY_CYC + 1);
    localparam logic [CW-1:0] LAST = CW'(DLY_CYC - 1);

    lin_mode_e     mode_q, mode_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic          want_norm, want_sleep, pend, expire, wake_ok;

    // Decide the next mode and the settling-count update.
    always_comb begin
        want_norm  = (mode_q != MODE_NORM) && en_lvl;
        want_sleep = (mode_q == MODE_NORM) && !en_lvl;
        pend       = want_norm || want_sleep;
        expire     = pend && (cnt_q == LAST);
        wake_ok    = (mode_q == MODE_SLEEP) && !en_lvl && !por;
        acc_loc    = wake_ok && wake_local;
        acc_bus    = wake_ok && wake_bus && !wake_local;
        enter_norm = !por && expire && want_norm;
        mode_d     = mode_q;
        if (por)                   mode_d = MODE_STBY;
        else if (expire)           mode_d = want_norm ? MODE_NORM : MODE_SLEEP;
        else if (acc_loc || acc_bus) mode_d = MODE_STBY;
        cnt_d = (por || !pend || expire) ? '0 : cnt_q + 1'b1;
    end

    // Mode and settling-count registers; reset means power-up into stand-by.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= MODE_STBY;
            cnt_q  <= '0;
        end else begin
            mode_q <= mode_d;
            cnt_q  <= cnt_d;
        end
    end

    assign mode = mode_q;

    // R9: a power-on reset always lands in stand-by.
    a_r9_por_to_stby: assert property (@(posedge clk) disable iff (!rst_n)
        por |=> (mode_q == MODE_STBY));

    // R6: an accepted bus wake in sleep lands in stand-by.
    a_r6_bus_wake: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_SLEEP && wake_bus && !en_lvl && !por) |=> (mode_q == MODE_STBY));

    // R2: normal is never reached without a synchronized enable.
    a_r2_norm_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q != MODE_NORM && !en_lvl) |=> (mode_q != MODE_NORM));

    // R4: normal never falls to sleep while enable is still high.
    a_r4_no_early_sleep: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_NORM && en_lvl) |=> (mode_q != MODE_SLEEP));

    // R10: wake strobes do not move the block out of stand-by.
    a_r10_stby_ignores_wake: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_STBY && !en_lvl && !por) |=> (mode_q == MODE_STBY));
endmodule

// File: rtl/lin_wake_flags.sv
// Wake-source latch.
// Records why stand-by was entered: power-up, bus or local.
// Power-on reset wins over a local wake, which wins over a bus wake.
// Cleared to none on entry to normal mode.
module lin_wake_flags
    import lin_mode_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      por,
    input  logic      acc_bus,
    input  logic      acc_loc,
    input  logic      enter_norm,
    output wake_src_e src
);
    wake_src_e src_q;

    // Latch the wake source by priority.
    always_ff @(posedge clk) begin
        if (!rst_n)          src_q <= SRC_POWER;
        else if (por)        src_q <= SRC_POWER;
        else if (acc_loc)    src_q <= SRC_LOCAL;
        else if (acc_bus)    src_q <= SRC_BUS;
        else if (enter_norm) src_q <= SRC_NONE;
    end

    assign src = src_q;

    // R9: a power-on reset records power-up as the source.
    a_r9_src_power: assert property (@(posedge clk) disable iff (!rst_n)
        por |=> (src_q == SRC_POWER));

    // R7: an accepted local wake records the local source.
    a_r7_src_local: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_loc && !por) |=> (src_q == SRC_LOCAL));

    // R11: entering normal clears the source.
    a_r11_clear_on_norm: assert property (@(posedge clk) disable iff (!rst_n)
        (enter_norm && !acc_loc && !acc_bus) |=> (src_q == SRC_NONE));
endmodule

// File: rtl/lin_pin_ctrl.sv
// Pin-control decode.
// Maps the mode and the latched wake source onto the stage enables,
// the receive-data level and the pull-down strength select. Purely combinational.
module lin_pin_ctrl
    import lin_mode_pkg::*;
(
    input  lin_mode_e mode,
    input  wake_src_e src,
    input  logic      bus_rx,
    output stage_en_t en,
    output logic      rxd_out,
    output logic      txd_pd_strong
);
    // Decode outputs per mode; stand-by reports the wake source.
    always_comb begin
        en            = '0;
        rxd_out       = 1'b1;
        txd_pd_strong = 1'b0;
        unique case (mode)
            MODE_NORM: begin
                en      = '{inh: 1'b1, term: 1'b1, tx: 1'b1, rx: 1'b1};
                rxd_out = bus_rx;
            end
            MODE_STBY: begin
                en            = '{inh: 1'b1, term: 1'b1, tx: 1'b0, rx: 1'b0};
                rxd_out       = !(src == SRC_BUS || src == SRC_LOCAL);
                txd_pd_strong = (src == SRC_LOCAL);
            end
            default: begin
                en      = '0;
                rxd_out = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/lin_mode_ctrl.sv
// Top of the LIN physical-layer mode controller.
// Synchronizes the enable pin, runs the mode machine, latches the wake
// source and decodes the pin controls.
// Assumes CLK_HZ is a whole number of MHz.
module lin_mode_ctrl
    import lin_mode_pkg::*;
#(
    parameter int CLK_HZ      = 200_000_000,
    parameter int DELAY_US    = 10,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_pin,
    input  logic por_pulse,
    input  logic wake_bus,
    input  logic wake_local,
    input  logic bus_rx,
    output logic inh_en,
    output logic term_en,
    output logic tx_en,
    output logic rx_en,
    output logic rxd_out,
    output logic txd_pd_strong
);
    localparam int DLY_RAW = (CLK_HZ / 1_000_000) * DELAY_US;
    localparam int DLY_CYC = (DLY_RAW < 1) ? 1 : DLY_RAW;

    logic      en_lvl, acc_bus, acc_loc, enter_norm;
    lin_mode_e mode;
    wake_src_e src;
    stage_en_t stg;

    lin_en_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .en_pin(en_pin), .en_lvl(en_lvl)
    );

    lin_mode_fsm #(.DLY_CYC(DLY_CYC)) u_fsm (
        .clk(clk), .rst_n(rst_n), .en_lvl(en_lvl), .por(por_pulse),
        .wake_bus(wake_bus), .wake_local(wake_local), .mode(mode),
        .acc_bus(acc_bus), .acc_loc(acc_loc), .enter_norm(enter_norm)
    );

    lin_wake_flags u_flags (
        .clk(clk), .rst_n(rst_n), .por(por_pulse), .acc_bus(acc_bus),
        .acc_loc(acc_loc), .enter_norm(enter_norm), .src(src)
    );

    lin_pin_ctrl u_pins (
        .mode(mode), .src(src), .bus_rx(bus_rx), .en(stg),
        .rxd_out(rxd_out), .txd_pd_strong(txd_pd_strong)
    );

    assign inh_en  = stg.inh;
    assign term_en = stg.term;
    assign tx_en   = stg.tx;
    assign rx_en   = stg.rx;

    // R5: the transmitter is never enabled without the inhibit output.
    a_r5_tx_needs_inh: assert property (@(posedge clk) disable iff (!rst_n)
        tx_en |-> inh_en);
endmodule

// File: tb/lin_mode_ctrl_tb.sv
`timescale 1ns/1ps
module lin_mode_ctrl_tb_top;
    localparam int DLY = 10;

    logic clk = 1'b0, rst_n = 1'b0, en_pin = 1'b0, por_pulse = 1'b0;
    logic wake_bus = 1'b0, wake_local = 1'b0, bus_rx = 1'b1;
    logic inh_en, term_en, tx_en, rx_en, rxd_out, txd_pd_strong;
    int   n_chk = 0, n_err = 0;

    // Reference model state: mode 0 sleep, 1 stand-by, 2 normal;
    // source 0 none, 1 power, 2 bus, 3 local.
    int m_mode = 1, m_src = 1, m_cnt = 0;
    bit m_s1 = 0, m_s2 = 0;

    always #2.5 clk = ~clk;

    lin_mode_ctrl #(.CLK_HZ(1_000_000), .DELAY_US(DLY)) dut_i (
        .clk(clk), .rst_n(rst_n), .en_pin(en_pin), .por_pulse(por_pulse),
        .wake_bus(wake_bus), .wake_local(wake_local), .bus_rx(bus_rx),
        .inh_en(inh_en), .term_en(term_en), .tx_en(tx_en), .rx_en(rx_en),
        .rxd_out(rxd_out), .txd_pd_strong(txd_pd_strong)
    );

    // Cycle-level model built from the requirements.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_mode = 1; m_src = 1; m_cnt = 0; m_s1 = 0; m_s2 = 0;
        end else begin
            if (por_pulse) begin
                m_mode = 1; m_src = 1; m_cnt = 0;
            end else if (m_mode != 2 && m_s2) begin
                if (m_cnt == DLY - 1) begin m_mode = 2; m_src = 0; m_cnt = 0; end
                else m_cnt++;
            end else if (m_mode == 2 && !m_s2) begin
                if (m_cnt == DLY - 1) begin m_mode = 0; m_cnt = 0; end
                else m_cnt++;
            end else begin
                m_cnt = 0;
                if (m_mode == 0 && wake_local) begin m_mode = 1; m_src = 3; end
                else if (m_mode == 0 && wake_bus) begin m_mode = 1; m_src = 2; end
            end
            m_s2 = m_s1; m_s1 = en_pin;
        end
    end

    function automatic logic [5:0] exp_out(int md, int sr, logic brx);
        case (md)
            0:       return 6'b000010;
            1:       return {4'b1100, !(sr == 2 || sr == 3), (sr == 3)};
            default: return {4'b1111, brx, 1'b0};
        endcase
    endfunction

    function automatic logic [5:0] outs();
        return {inh_en, term_en, tx_en, rx_en, rxd_out, txd_pd_strong};
    endfunction

    task automatic check(string tag, logic [5:0] got, logic [5:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_err++;
            $display("FAIL %s: got %b expected %b at %0t", tag, got, exp, $time);
        end
    endtask

    task automatic cyc(int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic finish_run();
        $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    endtask

    initial begin
        #(200000 * 5);
        n_err++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        cyc(3);
        rst_n = 1'b1;
        cyc(1);
        check("R1 reset state", outs(), 6'b110010);

        // R2: exact delay into normal
        en_pin = 1'b1;
        cyc(DLY + 1);
        check("R2 before delay", outs(), 6'b110010);
        bus_rx = 1'b0;
        cyc(1);
        check("R2 normal reached", outs(), 6'b111100);
        bus_rx = 1'b1; #1;
        check("R3 rxd follows bus", outs(), 6'b111110);

        // R4: cancelled countdown, then real sleep
        en_pin = 1'b0; cyc(5);
        en_pin = 1'b1; cyc(DLY + 4);
        check("R4 cancel keeps normal", outs(), 6'b111110);
        en_pin = 1'b0; cyc(DLY + 3);
        check("R5 sleep outputs", outs(), 6'b000010);

        // R6: bus wake
        wake_bus = 1'b1; cyc(1); wake_bus = 1'b0;
        check("R6 bus wake", outs(), 6'b110000);
        // R10: wake in stand-by ignored
        wake_local = 1'b1; cyc(1); wake_local = 1'b0; cyc(2);
        check("R10 stby ignores local wake", outs(), 6'b110000);

        // R11 clear on normal, back to sleep, then both wakes: R7
        en_pin = 1'b1; cyc(DLY + 3);
        check("R11 normal after wake", outs(), 6'b111110);
        wake_bus = 1'b1; cyc(1); wake_bus = 1'b0;
        check("R10 normal ignores bus wake", outs(), 6'b111110);
        en_pin = 1'b0; cyc(DLY + 3);
        wake_bus = 1'b1; wake_local = 1'b1; cyc(1);
        wake_bus = 1'b0; wake_local = 1'b0;
        check("R7 local beats bus", outs(), 6'b110001);

        // R9: por in stand-by resets the source
        por_pulse = 1'b1; cyc(1); por_pulse = 1'b0;
        check("R9 por in stby", outs(), 6'b110010);

        // R8: wake ignored while enable synchronized high in sleep
        en_pin = 1'b1; cyc(DLY + 3);
        en_pin = 1'b0; cyc(DLY + 3);
        check("R5 sleep again", outs(), 6'b000010);
        en_pin = 1'b1; cyc(3);
        wake_local = 1'b1; cyc(1); wake_local = 1'b0;
        check("R8 wake ignored", outs(), 6'b000010);
        cyc(DLY);
        check("R8 straight to normal", outs(), 6'b111110);

        // R9: por in normal restarts countdown
        por_pulse = 1'b1; cyc(1); por_pulse = 1'b0;
        check("R9 por in normal", outs(), 6'b110010);
        cyc(DLY - 1);
        check("R9 countdown restarted", outs(), 6'b110010);
        cyc(1);
        check("R9 normal after restart", outs(), 6'b111110);

        // Random phase against the model
        void'($urandom(32'h1d5e));
        for (int i = 0; i < 4000; i++) begin
            @(negedge clk);
            check(m_mode == 2 ? "R3 random" : (m_mode == 0 ? "R5 random" : "R6 random"),
                  outs(), exp_out(m_mode, m_src, bus_rx));
            wake_bus   = ($urandom_range(0, 19) == 0);
            wake_local = ($urandom_range(0, 24) == 0);
            por_pulse  = ($urandom_range(0, 199) == 0);
            bus_rx     = $urandom_range(0, 1);
            if ($urandom_range(0, 29) == 0) en_pin = ~en_pin;
            #1;
            check("R3 random comb", outs(), exp_out(m_mode, m_src, bus_rx));
        end
        finish_run();
    end
endmodule